// File: doc/BRIEF.md
# Rotating-Priority Eight-Line Interrupt Controller

This block gathers eight interrupt request lines, records each rising edge in a request register, filters the requests with a per-line mask, and arbitrates the survivors against the lines that are already being serviced. When a request outranks everything in service, a single interrupt output goes high. The processor answers with a one-cycle acknowledge. The controller then returns an 8-bit vector, equal to a programmed base plus the winning line number, and moves that line into the in-service register.

Software drives the block through a two-address byte port. Address 0 carries commands and returns the request or in-service register. Address 1 carries the initialization bytes, then the mask, and always reads back the mask. A write to address 0 with bit 4 set restarts the controller and opens an ordered initialization sequence. Once that sequence is done, commands on address 0 do three things: retire the top in-service line, rotate priority so that a chosen line becomes the lowest, and choose which register address 0 returns. An optional automatic end-of-interrupt mode leaves the in-service register untouched when an acknowledge is taken.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A write to address 0 with bit 4 set restarts the controller. It sets the mask to 0xFF, clears the request and in-service registers, makes line 7 the lowest priority and selects the request register for address-0 reads. The interrupt output stays low until the sequence completes.
- R2: After that restart, the following address-1 writes are taken in order. The first is the vector base. The second has no effect. The third is the mode byte, but only when bit 0 of the restart byte was 1; otherwise the sequence ends after the second byte with normal end-of-interrupt. After the sequence, address-1 writes load the mask, and address-1 reads always return the mask.
- R3: A rising edge on a request line sets that line's request bit, whether the line is masked or not. A line held high does not request again.
- R4: A line whose mask bit is 1 never raises the interrupt output.
- R5: The interrupt output is high exactly when initialization is complete and the highest-ranked unmasked request outranks every in-service line.
- R6: An acknowledge taken while the interrupt output is high produces a `vec_valid` pulse on the next cycle, lasting one cycle, with `vec_out` = base + line. The line's request bit clears, and its in-service bit sets when bit 1 of the mode byte is 0. An acknowledge taken while the output is low does nothing.
- R7: When bit 1 of the mode byte is 1 (automatic end-of-interrupt), an acknowledge leaves the in-service register unchanged.
- R8: Writing 0x20 to address 0 (bits 7:5 = 001, bits 4 and 3 = 0) clears the highest-ranked set bit of the in-service register.
- R9: An address-0 write with bit 4 = 0, bit 3 = 1 and bit 1 = 1 selects what address-0 reads return: the request register when bit 0 = 0 (0x0A), the in-service register when bit 0 = 1 (0x0B).
- R10: Writing 0xC0 | n to address 0 (bits 7:5 = 110) makes line n the lowest priority. The ranking then runs n+1, n+2, … up to n, wrapping modulo 8.
- R11: After reset or initialization, line 0 has the highest priority and line 7 the lowest.
- R12: Synchronous reset leaves the controller uninitialized: the interrupt output is low, the mask is 0xFF, and the request and in-service registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Request lines, one per line number |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 1 | Port address (0 command/status, 1 data/mask) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| irq_out | output | 1 | Interrupt request to the processor |
| int_ack | input | 1 | One-cycle acknowledge from the processor |
| vec_valid | output | 1 | Vector valid, one cycle after a taken acknowledge |
| vec_out | output | 8 | Vector: base plus granted line number |

## Verification
The in-service counting properties assume that an acknowledge, a command write and a restart never fall in the same cycle. Under that assumption each taken acknowledge adds exactly one in-service bit, or none in automatic mode, and each end-of-interrupt removes exactly one. The vector property assumes that the acknowledge is a single-cycle pulse. The randomized stimulus issues at most one operation per cycle, whether a line toggle, an acknowledge, a command or a mask write, so all three assumptions hold while orderings, masks, bases and nesting still vary widely.

// File: rtl/pic_pkg.sv
`timescale 1ns/1ps
package pic_pkg;
    localparam int NLINES = 8;
    localparam int LW     = $clog2(NLINES);
    localparam int DW     = 8;

    typedef enum logic [2:0] {
        CFG_OFF,
        CFG_BASE,
        CFG_CASC,
        CFG_MODE,
        CFG_RUN
    } cfg_state_e;

    typedef enum logic {
        SEL_REQ,
        SEL_SVC
    } rd_sel_e;

    typedef struct packed {
        logic          hit;
        logic [LW-1:0] idx;
    } pick_t;

    // Rank 0 is the highest priority; the line just above 'lowest' gets rank 0.
    function automatic logic [LW-1:0] rank_of(logic [LW-1:0] idx, logic [LW-1:0] lowest);
        return idx - lowest - LW'(1);
    endfunction

    // First set bit scanning from the highest-ranked line downwards.
    function automatic pick_t pick_first(logic [NLINES-1:0] v, logic [LW-1:0] lowest);
        pick_t         r;
        logic [LW-1:0] i;
        r = '0;
        for (int k = 0; k < NLINES; k++) begin
            i = lowest + LW'(k) + LW'(1);
            if (!r.hit && v[i]) begin
                r.hit = 1'b1;
                r.idx = i;
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/pic_cfg.sv
`timescale 1ns/1ps
module pic_cfg
    import pic_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              addr,
    input  logic [DW-1:0]     wr_data,
    output logic              run,
    output logic [DW-1:0]     base,
    output logic              aeoi,
    output logic [NLINES-1:0] imr,
    output logic [LW-1:0]     lowest,
    output rd_sel_e           rd_sel,
    output logic              clr_all,
    output logic              eoi_cmd
);
    cfg_state_e st;
    logic       want_mode;

    logic init_wr, cmd_wr, data_wr;
    assign init_wr = wr_en && !addr && wr_data[4];
    assign cmd_wr  = wr_en && !addr && !wr_data[4] && (st == CFG_RUN);
    assign data_wr = wr_en && addr;

    assign clr_all = init_wr;
    assign eoi_cmd = cmd_wr && !wr_data[3] && (wr_data[7:5] == 3'b001);
    assign run     = (st == CFG_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= CFG_OFF;
            want_mode <= 1'b0;
            base      <= '0;
            aeoi      <= 1'b0;
            imr       <= '1;
            lowest    <= LW'(NLINES - 1);
            rd_sel    <= SEL_REQ;
        end else if (init_wr) begin
            st        <= CFG_BASE;
            want_mode <= wr_data[0];
            aeoi      <= 1'b0;
            imr       <= '1;
            lowest    <= LW'(NLINES - 1);
            rd_sel    <= SEL_REQ;
        end else if (data_wr) begin
            case (st)
                CFG_BASE: begin
                    base <= wr_data;
                    st   <= CFG_CASC;
                end
                CFG_CASC: st <= want_mode ? CFG_MODE : CFG_RUN;
                CFG_MODE: begin
                    aeoi <= wr_data[1];
                    st   <= CFG_RUN;
                end
                CFG_RUN:  imr <= wr_data;
                default:  ;
            endcase
        end else if (cmd_wr) begin
            if (wr_data[3]) begin
                if (wr_data[1])
                    rd_sel <= wr_data[0] ? SEL_SVC : SEL_REQ;
            end else if (wr_data[7:5] == 3'b110) begin
                lowest <= wr_data[LW-1:0];
            end
        end
    end

    p_restart_state_r1: assert property (@(posedge clk) disable iff (rst)
        init_wr |=> (imr == '1 && !run && rd_sel == SEL_REQ));

    p_mask_load_r2: assert property (@(posedge clk) disable iff (rst)
        (data_wr && run) |=> (imr == $past(wr_data)));

    p_rotate_r10: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && wr_data[7:5] == 3'b110 && !wr_data[3]) |=> (lowest == $past(wr_data[LW-1:0])));
endmodule

// File: rtl/pic_req.sv
`timescale 1ns/1ps
module pic_req
    import pic_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NLINES-1:0] lines,
    input  logic              clr_all,
    input  logic [NLINES-1:0] take,
    output logic [NLINES-1:0] irr
);
    logic [NLINES-1:0] prev;
    logic [NLINES-1:0] rise;
    assign rise = lines & ~prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= '0;
            irr  <= '0;
        end else begin
            prev <= lines;
            if (clr_all) irr <= '0;
            else         irr <= (irr & ~take) | rise;
        end
    end

    p_edge_capture_r3: assert property (@(posedge clk) disable iff (rst)
        (rise != '0 && !clr_all) |=> ((irr & $past(rise)) == $past(rise)));

    p_restart_clear_r1: assert property (@(posedge clk) disable iff (rst)
        clr_all |=> (irr == '0));
endmodule

// File: rtl/pic_svc.sv
`timescale 1ns/1ps
module pic_svc
    import pic_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NLINES-1:0] irr,
    input  logic [NLINES-1:0] imr,
    input  logic [LW-1:0]     lowest,
    input  logic              aeoi,
    input  logic              run,
    input  logic [DW-1:0]     base,
    input  logic              ack,
    input  logic              eoi,
    input  logic              clr_all,
    output logic [NLINES-1:0] isr,
    output logic              irq,
    output logic [NLINES-1:0] take,
    output logic              vec_valid,
    output logic [DW-1:0]     vec
);
    pick_t             req_pick, svc_pick;
    logic              grant;
    logic [NLINES-1:0] isr_nxt;

    assign req_pick = pick_first(irr & ~imr, lowest);
    assign svc_pick = pick_first(isr, lowest);

    assign irq = run && req_pick.hit &&
                 (!svc_pick.hit || (rank_of(req_pick.idx, lowest) < rank_of(svc_pick.idx, lowest)));
    assign grant = ack && irq;
    assign take  = grant ? (NLINES'(1) << req_pick.idx) : '0;

    always_comb begin
        isr_nxt = isr;
        if (eoi && svc_pick.hit) isr_nxt[svc_pick.idx] = 1'b0;
        if (grant && !aeoi)      isr_nxt = isr_nxt | take;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            isr       <= '0;
            vec_valid <= 1'b0;
            vec       <= '0;
        end else begin
            vec_valid <= grant;
            if (grant) vec <= base + DW'(req_pick.idx);
            if (clr_all) isr <= '0;
            else         isr <= isr_nxt;
        end
    end

    p_mask_blocks_r4: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((irr & ~imr) != '0));

    p_vec_after_ack_r6: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> $past(ack));

    p_isr_push_r6: assert property (@(posedge clk) disable iff (rst)
        (grant && !aeoi && !eoi && !clr_all) |=> ($countones(isr) == $countones($past(isr)) + 1));

    p_aeoi_keep_r7: assert property (@(posedge clk) disable iff (rst)
        (grant && aeoi && !eoi && !clr_all) |=> (isr == $past(isr)));

    p_eoi_pop_r8: assert property (@(posedge clk) disable iff (rst)
        (eoi && isr != '0 && !ack && !clr_all) |=> ($countones(isr) == $countones($past(isr)) - 1));
endmodule

// File: rtl/prio_irq_ctrl.sv
`timescale 1ns/1ps
module prio_irq_ctrl
    import pic_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NLINES-1:0] irq_in,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              irq_out,
    input  logic              int_ack,
    output logic              vec_valid,
    output logic [DW-1:0]     vec_out
);
    logic              run, aeoi, clr_all, eoi_cmd;
    logic [DW-1:0]     base;
    logic [NLINES-1:0] imr, irr, isr, take;
    logic [LW-1:0]     lowest;
    rd_sel_e           rd_sel;

    pic_cfg u_cfg (
        .clk(clk), .rst(rst), .wr_en(bus_wr), .addr(bus_addr), .wr_data(bus_wdata),
        .run(run), .base(base), .aeoi(aeoi), .imr(imr), .lowest(lowest),
        .rd_sel(rd_sel), .clr_all(clr_all), .eoi_cmd(eoi_cmd)
    );

    pic_req u_req (
        .clk(clk), .rst(rst), .lines(irq_in), .clr_all(clr_all), .take(take), .irr(irr)
    );

    pic_svc u_svc (
        .clk(clk), .rst(rst), .irr(irr), .imr(imr), .lowest(lowest), .aeoi(aeoi),
        .run(run), .base(base), .ack(int_ack), .eoi(eoi_cmd), .clr_all(clr_all),
        .isr(isr), .irq(irq_out), .take(take), .vec_valid(vec_valid), .vec(vec_out)
    );

    always_comb begin
        if (bus_addr)               bus_rdata = imr;
        else if (rd_sel == SEL_SVC) bus_rdata = isr;
        else                        bus_rdata = irr;
    end

    p_reset_quiet_r12: assert property (@(posedge clk)
        $past(rst) |-> (!irq_out && bus_rdata == (bus_addr ? 8'hFF : 8'h00)));
endmodule

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] irq_in = '0;
    logic       bus_wr = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq_out;
    logic       int_ack = 1'b0;
    logic       vec_valid;
    logic [7:0] vec_out;

    always #2.5 clk = ~clk;

    prio_irq_ctrl u_dut (
        .clk(clk), .rst(rst), .irq_in(irq_in), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out),
        .int_ack(int_ack), .vec_valid(vec_valid), .vec_out(vec_out)
    );

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 0;

    // Reference state built from the requirements.
    logic [7:0] m_irr, m_isr, m_imr, m_base, m_prev, exp_vec;
    logic [2:0] m_low;
    bit         m_aeoi, m_sel, m_want, exp_valid;
    int         m_st;   // 0 off, 1 base, 2 second byte, 3 mode, 4 running

    function automatic logic [2:0] brank(int i, logic [2:0] low);
        return 3'(i - int'(low) - 1);
    endfunction

    function automatic int top_line(logic [7:0] v, logic [2:0] low);
        int best = -1;
        for (int i = 0; i < 8; i++)
            if (v[i] && (best < 0 || brank(i, low) < brank(best, low))) best = i;
        return best;
    endfunction

    function automatic bit m_irq();
        int p = top_line(m_irr & ~m_imr, m_low);
        int s = top_line(m_isr, m_low);
        return (m_st == 4) && p >= 0 && (s < 0 || brank(p, m_low) < brank(s, m_low));
    endfunction

    task automatic model_reset();
        m_irr = 0; m_isr = 0; m_imr = 8'hFF; m_base = 0; m_prev = 0; m_low = 7;
        m_aeoi = 0; m_sel = 0; m_want = 0; m_st = 0; exp_valid = 0; exp_vec = 0;
    endtask

    task automatic model_step();
        int p = top_line(m_irr & ~m_imr, m_low);
        int s = top_line(m_isr, m_low);
        bit g = int_ack && m_irq();
        logic [7:0] rise = irq_in & ~m_prev;
        logic [7:0] isr_n = m_isr;
        m_prev = irq_in;
        exp_valid = g;
        if (g) exp_vec = m_base + 8'(p);
        if (bus_wr && !bus_addr && bus_wdata[4]) begin
            m_st = 1; m_want = bus_wdata[0]; m_aeoi = 0; m_imr = 8'hFF;
            m_low = 7; m_sel = 0; m_irr = 0; m_isr = 0;
        end else begin
            if (g) begin
                m_irr[p] = 1'b0;
                if (!m_aeoi) isr_n[p] = 1'b1;
            end
            m_irr = m_irr | rise;
            if (bus_wr && !bus_addr && m_st == 4) begin
                if (bus_wdata[3]) begin
                    if (bus_wdata[1]) m_sel = bus_wdata[0];
                end else if (bus_wdata[7:5] == 3'b001) begin
                    if (s >= 0) isr_n[s] = 1'b0;
                end else if (bus_wdata[7:5] == 3'b110) begin
                    m_low = bus_wdata[2:0];
                end
            end
            if (bus_wr && bus_addr) begin
                case (m_st)
                    1: begin m_base = bus_wdata; m_st = 2; end
                    2: m_st = m_want ? 3 : 4;
                    3: begin m_aeoi = bus_wdata[1]; m_st = 4; end
                    4: m_imr = bus_wdata;
                    default: ;
                endcase
            end
            m_isr = isr_n;
        end
    endtask

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic peek(logic a, output logic [7:0] v);
        bus_addr = a;
        #0.2;
        v = bus_rdata;
    endtask

    // One clock: update the model for the edge, then compare every output.
    task automatic tick();
        logic [7:0] v;
        @(posedge clk);
        #1;
        model_step();
        bus_wr = 0; int_ack = 0;
        chk(irq_out == m_irq(), "R5 irq_out", irq_out, m_irq());
        chk(vec_valid == exp_valid, "R6 vec_valid", vec_valid, exp_valid);
        if (exp_valid) chk(vec_out == exp_vec, "R6 vec_out", vec_out, exp_vec);
        peek(1'b0, v);
        chk(v == (m_sel ? m_isr : m_irr), "R9 addr0 read", v, m_sel ? m_isr : m_irr);
        peek(1'b1, v);
        chk(v == m_imr, "R2 addr1 read", v, m_imr);
        bus_addr = 0;
    endtask

    task automatic wr(logic a, logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        tick();
    endtask

    task automatic ack();
        int_ack = 1;
        tick();
    endtask

    task automatic set_lines(logic [7:0] l);
        irq_in = l;
        tick();
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R12: uninitialized state after reset
        tick();
        chk(irq_out == 0, "R12 irq low after reset", irq_out, 0);
        peek(1'b1, v); chk(v == 8'hFF, "R12 mask after reset", v, 8'hFF);
        peek(1'b0, v); chk(v == 8'h00, "R12 request reg after reset", v, 0);
        set_lines(8'h01);
        chk(irq_out == 0, "R12 no irq before init", irq_out, 0);
        set_lines(8'h00);

        // R1 / R2: initialization sequence, base 0x20, normal EOI
        wr(0, 8'h11);
        peek(1'b1, v); chk(v == 8'hFF, "R1 mask set by restart", v, 8'hFF);
        peek(1'b0, v); chk(v == 8'h00, "R1 request reg cleared", v, 0);
        wr(1, 8'h20); wr(1, 8'h00); wr(1, 8'h01);
        wr(1, 8'h00);
        peek(1'b1, v); chk(v == 8'h00, "R2 mask loaded after sequence", v, 0);

        // R11 / R5 / R6: lines 3 and 5, line 3 wins
        set_lines(8'h28);
        chk(irq_out == 1, "R5 irq on pending request", irq_out, 1);
        ack();
        chk(vec_valid && vec_out == 8'h23, "R11 line 3 before 5, vector", vec_out, 8'h23);
        chk(irq_out == 0, "R5 lower request blocked by in-service", irq_out, 0);
        tick();
        chk(vec_valid == 0, "R6 vector valid lasts one cycle", vec_valid, 0);
        wr(0, 8'h0B);
        peek(1'b0, v); chk(v == 8'h08, "R9 in-service readback", v, 8'h08);
        wr(0, 8'h0A);
        peek(1'b0, v); chk(v == 8'h20, "R9 request readback after grant", v, 8'h20);

        // R5 nesting and R8 non-specific EOI
        set_lines(8'h2A);
        chk(irq_out == 1, "R5 higher line nests", irq_out, 1);
        ack();
        chk(vec_out == 8'h21, "R6 nested vector", vec_out, 8'h21);
        wr(0, 8'h20);
        wr(0, 8'h0B);
        peek(1'b0, v); chk(v == 8'h08, "R8 EOI clears highest in-service", v, 8'h08);
        wr(0, 8'h20);
        chk(irq_out == 1, "R5 pending line 5 released", irq_out, 1);
        ack();
        chk(vec_out == 8'h25, "R6 line 5 vector", vec_out, 8'h25);
        wr(0, 8'h20);
        wr(0, 8'h0A);

        // R3: held lines do not re-request
        tick(); tick();
        peek(1'b0, v); chk(v == 8'h00, "R3 held line no new request", v, 0);

        // R4: masked line recorded but silent
        wr(1, 8'h10);
        set_lines(8'h3A);
        chk(irq_out == 0, "R4 masked line no irq", irq_out, 0);
        peek(1'b0, v); chk(v == 8'h10, "R3 masked request recorded", v, 8'h10);
        wr(1, 8'h00);
        chk(irq_out == 1, "R4 unmask releases request", irq_out, 1);
        ack();
        chk(vec_out == 8'h24, "R4 line 4 vector", vec_out, 8'h24);
        wr(0, 8'h20);

        // R10: line 2 lowest, so 3 beats 1
        wr(0, 8'hC2);
        set_lines(8'h00);
        set_lines(8'h0A);
        ack();
        chk(vec_out == 8'h23, "R10 rotated priority line 3 first", vec_out, 8'h23);
        wr(0, 8'h20);
        ack();
        chk(vec_out == 8'h21, "R10 rotated priority line 1 next", vec_out, 8'h21);
        wr(0, 8'h20);

        // R7: automatic EOI
        wr(0, 8'h11); wr(1, 8'h40); wr(1, 8'h00); wr(1, 8'h03); wr(1, 8'h00);
        set_lines(8'h00);
        set_lines(8'h04);
        ack();
        chk(vec_out == 8'h42, "R7 auto-EOI vector", vec_out, 8'h42);
        wr(0, 8'h0B);
        peek(1'b0, v); chk(v == 8'h00, "R7 in-service stays empty", v, 0);

        // R2: restart byte bit0 = 0 skips mode byte
        wr(0, 8'h10); wr(1, 8'h50); wr(1, 8'h00); wr(1, 8'h00);
        set_lines(8'h00);
        set_lines(8'h80);
        ack();
        chk(vec_out == 8'h57, "R2 short sequence vector", vec_out, 8'h57);
        wr(0, 8'h0B);
        peek(1'b0, v); chk(v == 8'h80, "R2 short sequence normal EOI", v, 8'h80);

        // Randomized phase checked against the model every cycle
        for (int n = 0; n < 4000; n++) begin
            int r = $urandom % 16;
            if (r < 5)       set_lines(irq_in ^ (8'h01 << ($urandom % 8)));
            else if (r < 8)  ack();
            else if (r == 8) wr(0, 8'h20);
            else if (r == 9) wr(0, 8'hC0 | 8'($urandom % 8));
            else if (r == 10) wr(0, ($urandom % 2) ? 8'h0B : 8'h0A);
            else if (r == 11) wr(1, 8'($urandom));
            else if (r == 12 && ($urandom % 8) == 0) begin
                wr(0, 8'h11); wr(1, 8'($urandom)); wr(1, 8'h00);
                wr(1, ($urandom % 2) ? 8'h03 : 8'h01); wr(1, 8'($urandom));
            end else tick();
        end

        done = 1;
        summary();
        $finish;
    end
endmodule